// File: doc/BRIEF.md
# Double-Buffered Process-Data Exchange Memory

This block is a two-port shared memory between a communication side and an application side. Each side has its own memory port, and the two ports may read and write in the same clock cycle. Cyclic process data moves in two directions: inbound (the communication side writes, the application side reads) and outbound (the application side writes, the communication side reads). Each direction has two pages. One page belongs to the writer and one to the reader, so neither side ever waits for the other and no reader sees a half-written page.

A writer finishes a page with a one-cycle completion strobe, which swaps its page with the reader's page. While a reader holds its page through its hold input, the swap is deferred. During that time the writer keeps writing into its own page, and any number of completion strobes collapse into one swap. That swap is taken on the first edge at which the hold is low. Each inbound swap raises a fresh-data flag for the application side. The application side polls this flag at the start of its cycle and clears it with a strobe. If a set and a clear fall in the same cycle, the set wins.

Each port addresses only an offset within a page. The page base comes from the flip state. Writes on a port always go to the page that side owns for writing. Reads always come from the page that side owns for reading, with one cycle of latency.

Top module: `page_xchg`

## Requirements
- R1: Words written by the communication side into the inbound direction are not visible on `a_rdata` until a completion strobe `c_done` has been accepted. Until then the application side reads the previous inbound page.
- R2: After `c_done` is accepted at a clock edge, application reads issued from the next cycle onward return the words the communication side wrote before that edge.
- R3: `a_new` goes to 1 at the edge where an inbound swap is taken. It stays at 1 until it is cleared.
- R4: A pulse on `a_clr` makes `a_new` 0 after the next edge. If an inbound swap is taken in the same cycle as the clear, `a_new` stays at 1.
- R5: While `a_hold` is 1, no inbound swap takes place and `a_new` does not rise. The application side keeps reading its old page. A deferred swap is taken at the first edge at which `a_hold` is 0.
- R6: The outbound direction works the same way, with the roles exchanged. The application side writes, `a_done` swaps, and the communication side reads the page on `c_rdata`. While `c_hold` is 1, the outbound swap is deferred.
- R7: Each read port has one cycle of latency. `rdata` shows the word at the address sampled on the previous edge, and it holds that value while the address changes between edges.
- R8: After reset, `a_new` is 0 and both `c_rdata` and `a_rdata` are 0.
- R9: Both ports may write and read in the same cycle without affecting each other's data.
- R10: Several completion strobes given while the reader holds its page result in exactly one swap. After release, the reader sees the last data the writer wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c_addr | input | AW | Communication-side word offset within a page |
| c_we | input | 1 | Communication-side write to its inbound page |
| c_wdata | input | DW | Communication-side write data |
| c_rdata | output | DW | Communication-side read data from its outbound page |
| c_done | input | 1 | Inbound page complete strobe |
| c_hold | input | 1 | Communication side holds its outbound read page |
| a_addr | input | AW | Application-side word offset within a page |
| a_we | input | 1 | Application-side write to its outbound page |
| a_wdata | input | DW | Application-side write data |
| a_rdata | output | DW | Application-side read data from its inbound page |
| a_done | input | 1 | Outbound page complete strobe |
| a_hold | input | 1 | Application side holds its inbound read page |
| a_new | output | 1 | Fresh inbound data flag |
| a_clr | input | 1 | Clear strobe for `a_new` |

## Verification
A read presented between edges returns its data after the next rising edge. A completion strobe flips the page selection at the edge that samples it, so a read issued in the following cycle sees the new page one further edge later. `a_new` changes at the same edge as the swap, and a clear takes effect after a single edge. The bench drives every input just after a falling edge and samples every output at the next falling edge, which places each check half a period after the edge where the result is due. It sweeps every offset of a small page configuration over several rounds of arithmetic data patterns.

// File: rtl/page_xchg.sv
module page_xchg #(
  parameter int DW = 16,
  parameter int PW = 16,
  parameter int AW = $clog2(PW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] c_addr,
  input  logic          c_we,
  input  logic [DW-1:0] c_wdata,
  output logic [DW-1:0] c_rdata,
  input  logic          c_done,
  input  logic          c_hold,
  input  logic [AW-1:0] a_addr,
  input  logic          a_we,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          a_done,
  input  logic          a_hold,
  output logic          a_new,
  input  logic          a_clr
);
  localparam int NW = 4 * PW;
  localparam int MW = AW + 2;

  logic [DW-1:0] mem [NW];
  logic in_sel, out_sel, in_pend, out_pend;

  wire in_go  = (c_done | in_pend) & ~a_hold;
  wire out_go = (a_done | out_pend) & ~c_hold;

  wire [MW-1:0] c_wa = {1'b0, in_sel, c_addr};
  wire [MW-1:0] a_ra = {1'b0, ~in_sel, a_addr};
  wire [MW-1:0] a_wa = {1'b1, out_sel, a_addr};
  wire [MW-1:0] c_ra = {1'b1, ~out_sel, c_addr};

  always_ff @(posedge clk) begin
    if (c_we) mem[c_wa] <= c_wdata;
    if (a_we) mem[a_wa] <= a_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_rdata  <= '0;
      a_rdata  <= '0;
      in_sel   <= 1'b0;
      out_sel  <= 1'b0;
      in_pend  <= 1'b0;
      out_pend <= 1'b0;
      a_new    <= 1'b0;
    end else begin
      c_rdata  <= mem[c_ra];
      a_rdata  <= mem[a_ra];
      in_sel   <= in_sel ^ in_go;
      out_sel  <= out_sel ^ out_go;
      in_pend  <= (c_done | in_pend) & a_hold;
      out_pend <= (a_done | out_pend) & c_hold;
      a_new    <= in_go | (a_new & ~a_clr);
    end
  end
endmodule

// File: rtl/page_xchg_chk.sv
module page_xchg_chk (
  input logic clk,
  input logic rst_n,
  input logic c_done,
  input logic c_hold,
  input logic a_done,
  input logic a_hold,
  input logic a_clr,
  input logic a_new,
  input logic in_sel,
  input logic out_sel,
  input logic in_pend
);
  assert_flag_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && !a_hold) |=> a_new);

  assert_flag_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (a_new && !$past(a_new)) |-> (in_sel != $past(in_sel)));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (a_clr && !c_done && !in_pend) |=> !a_new);

  assert_hold_in_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_hold |=> $stable(in_sel));

  assert_defer_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (c_done && a_hold) |=> in_pend);

  assert_hold_out_R6: assert property (@(posedge clk) disable iff (!rst_n)
    c_hold |=> $stable(out_sel));

  assert_out_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (a_done && !c_hold) |=> (out_sel != $past(out_sel)));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pend && !a_hold) |=> (!in_pend && in_sel != $past(in_sel)));
endmodule

bind page_xchg page_xchg_chk u_chk (
  .clk(clk), .rst_n(rst_n), .c_done(c_done), .c_hold(c_hold),
  .a_done(a_done), .a_hold(a_hold), .a_clr(a_clr), .a_new(a_new),
  .in_sel(in_sel), .out_sel(out_sel), .in_pend(in_pend)
);

// File: tb/sim_page_xchg.sv
module sim_page_xchg;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int PW = 8;
  localparam int AW = $clog2(PW);

  logic clk = 0, rst_n = 0;
  logic [AW-1:0] c_addr = '0, a_addr = '0;
  logic c_we = 0, a_we = 0, c_done = 0, a_done = 0;
  logic c_hold = 0, a_hold = 0, a_clr = 0;
  logic [DW-1:0] c_wdata = '0, a_wdata = '0;
  logic [DW-1:0] c_rdata, a_rdata;
  logic a_new;
  int n_chk = 0, n_fail = 0;

  page_xchg #(.DW(DW), .PW(PW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .c_addr(c_addr), .c_we(c_we), .c_wdata(c_wdata), .c_rdata(c_rdata),
    .c_done(c_done), .c_hold(c_hold),
    .a_addr(a_addr), .a_we(a_we), .a_wdata(a_wdata), .a_rdata(a_rdata),
    .a_done(a_done), .a_hold(a_hold), .a_new(a_new), .a_clr(a_clr)
  );

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] pin(int r, int i);
    return DW'(r * 97 + i * 13 + 5);
  endfunction
  function automatic logic [DW-1:0] pout(int r, int i);
    return DW'(r * 51 + i * 7 + 300);
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic fill_in(int r);
    for (int i = 0; i < PW; i++) begin
      c_addr = AW'(i); c_wdata = pin(r, i); c_we = 1; step();
    end
    c_we = 0;
  endtask

  task automatic fill_out(int r);
    for (int i = 0; i < PW; i++) begin
      a_addr = AW'(i); a_wdata = pout(r, i); a_we = 1; step();
    end
    a_we = 0;
  endtask

  task automatic read_in(string req, int r);
    for (int i = 0; i < PW; i++) begin
      a_addr = AW'(i); step(); chk(req, a_rdata, pin(r, i));
    end
  endtask

  task automatic read_out(string req, int r);
    for (int i = 0; i < PW; i++) begin
      c_addr = AW'(i); step(); chk(req, c_rdata, pout(r, i));
    end
  endtask

  task automatic pulse_c_done(); c_done = 1; step(); c_done = 0; endtask
  task automatic pulse_a_done(); a_done = 1; step(); a_done = 0; endtask
  task automatic pulse_clr();    a_clr = 1;  step(); a_clr = 0;  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) step();
    chk("R8 a_new", a_new, 0);
    chk("R8 c_rdata", c_rdata, 0);
    chk("R8 a_rdata", a_rdata, 0);
    rst_n = 1;
    step();

    // R9: both sides fill, complete and read in the same cycles
    for (int r = 0; r < 4; r++) begin
      for (int i = 0; i < PW; i++) begin
        c_addr = AW'(i); c_wdata = pin(r, i); c_we = 1;
        a_addr = AW'(i); a_wdata = pout(r, i); a_we = 1;
        step();
      end
      c_we = 0; a_we = 0;
      if (r > 0) read_in("R1 old inbound page", r - 1);
      c_done = 1; a_done = 1; step(); c_done = 0; a_done = 0;
      chk("R3 flag set", a_new, 1);
      step(); step();
      chk("R3 flag held", a_new, 1);
      for (int i = 0; i < PW; i++) begin
        a_addr = AW'(i); c_addr = AW'(i); step();
        chk("R2 R9 inbound", a_rdata, pin(r, i));
        chk("R6 R9 outbound", c_rdata, pout(r, i));
      end
      pulse_clr();
      chk("R4 flag cleared", a_new, 0);
    end

    // R7: latency
    a_addr = AW'(2); step();
    chk("R7 data after edge", a_rdata, pin(3, 2));
    a_addr = AW'(5); #1;
    chk("R7 held between edges", a_rdata, pin(3, 2));
    step();
    chk("R7 next address", a_rdata, pin(3, 5));

    // R4: set and clear in the same cycle
    fill_in(10);
    c_done = 1; a_clr = 1; step(); c_done = 0; a_clr = 0;
    chk("R4 set wins", a_new, 1);
    read_in("R2 after set-wins swap", 10);
    pulse_clr();
    chk("R4 cleared again", a_new, 0);

    // R5 / R10: application hold defers inbound swap
    a_hold = 1;
    fill_in(20);
    pulse_c_done();
    chk("R5 no flag while held", a_new, 0);
    read_in("R5 old page while held", 10);
    fill_in(21);
    pulse_c_done();
    chk("R5 still no flag", a_new, 0);
    read_in("R5 still old page", 10);
    a_hold = 0;
    step();
    chk("R5 flag after release", a_new, 1);
    read_in("R10 latest data after release", 21);
    pulse_clr();
    step();
    chk("R10 single swap only", a_new, 0);

    // R6: communication hold defers outbound swap
    fill_out(30);
    pulse_a_done();
    read_out("R6 outbound page", 30);
    c_hold = 1;
    fill_out(31);
    pulse_a_done();
    read_out("R6 old outbound while held", 30);
    fill_out(32);
    pulse_a_done();
    read_out("R6 still old outbound", 30);
    c_hold = 0;
    step();
    read_out("R6 R10 outbound after release", 32);
    chk("R6 no inbound flag from outbound", a_new, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule